// File: doc/BRIEF.md
# Carry-Aware Add/Reverse-Subtract Unit

This block is a 32-bit integer adder that either adds two operands or subtracts the first operand from the second. For subtraction it adds the second operand, the bitwise inverse of the first operand and a carry-in. It owns the carry flag of a machine status word and drives the whole word as an output.

Each operation carries two modifiers. The use-carry modifier selects the carry-in. When it is set, the carry-in is the stored flag, so multi-word arithmetic can be chained. When it is clear, the carry-in is a fixed default that depends on the operation. The keep modifier stops the carry-out from being written back, so the stored flag survives the operation.

The result is registered and is marked by a one-cycle valid pulse. The status word changes on the same clock edge as the result.

Top module: `addsubc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the status word, the result and `resValid` to zero.
- R2: An add (`opSub`=0) with `useCarry`=0 yields `opA + opB` modulo 2^32, with a carry-in of 0.
- R3: A subtract (`opSub`=1) with `useCarry`=0 yields `opB + ~opA + 1`, which is `opB - opA` modulo 2^32.
- R4: With `useCarry`=1 the carry-in is bit 31 of the status word, for both add and subtract.
- R5: With `keep`=0 the carry-out of the 32-bit sum is written to status bit 2 and to its copy at status bit 31. Both bits become 1 when the carry-out is 1 and both become 0 when it is 0.
- R6: With `keep`=1 the status word is not changed, whatever the carry-out is.
- R7: An operation accepted at a clock edge (`opValid`=1) gives a one-cycle `resValid` pulse and the new `result` right after that edge. Without an operation, `resValid` stays low and `result` holds its value.
- R8: The status update takes effect on the same edge as the result. An operation issued in the very next cycle with `useCarry`=1 uses the updated carry.
- R9: Status bits other than 2 and 31 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Issues an operation this cycle |
| opA | input | 32 | First operand (the subtrahend in subtract mode) |
| opB | input | 32 | Second operand |
| opSub | input | 1 | 0 = add, 1 = reverse subtract |
| useCarry | input | 1 | Take the carry-in from status bit 31 |
| keep | input | 1 | Suppress the carry write-back |
| result | output | 32 | Registered result |
| resValid | output | 1 | One-cycle pulse marking a new result |
| statusWord | output | 32 | Machine status word (carry at bit 2, copy at bit 31) |

## Verification
The bench targets the carry boundaries. These are an add that wraps to zero, a subtract of equal operands (carry-out 1) and a subtract with a larger subtrahend (carry-out 0). A design that swapped the subtract defaults or did a - b instead of b - a would give wrong results or an inverted carry there. Chained operations with use-carry set, including a back-to-back pair, expose a carry-in taken from the wrong place or a write-back delayed by a cycle. Keep operations with a carry-out that differs from the stored flag expose a write that is not suppressed, and a design that updated only one of the two carry bits would show mismatched bits in the status word.

// File: rtl/addsubc_pkg.sv
package addsubc_pkg;
  typedef struct packed {
    logic load;        // capture result this cycle
    logic invA;        // invert first operand (reverse subtract)
    logic useFlag;     // carry-in from stored flag
    logic cinFixed;    // default carry-in when flag unused
    logic writeCarry;  // write carry-out back to status
  } ctrlStrobe_t;
endpackage

// File: rtl/addsubc_ctrl.sv
module addsubc_ctrl
  import addsubc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic        opSub,
  input  logic        useCarry,
  input  logic        keep,
  output ctrlStrobe_t strobe,
  output logic        resValid
);

  always_comb begin
    strobe.load       = opValid;
    strobe.invA       = opSub;
    strobe.useFlag    = useCarry;
    strobe.cinFixed   = opSub;
    strobe.writeCarry = opValid && !keep;
  end

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else     resValid <= opValid;
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    opValid |=> resValid);
  // R7
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> !resValid);

endmodule

// File: rtl/addsubc_dp.sv
module addsubc_dp
  import addsubc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STATUS_W  = 32,
  parameter int CARRY_BIT = 2,
  parameter int COPY_BIT  = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic [DATA_W-1:0]   result,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0]   aSel;
  logic                carryIn;
  logic [SUM_W-1:0]    sumWide;
  logic                carryOut;
  logic [STATUS_W-1:0] statusQ, statusD;
  logic [DATA_W-1:0]   resultQ;

  always_comb begin
    aSel     = strobe.invA ? ~opA : opA;
    carryIn  = strobe.useFlag ? statusQ[COPY_BIT] : strobe.cinFixed;
    sumWide  = {1'b0, opB} + {1'b0, aSel} + {{(SUM_W-1){1'b0}}, carryIn};
    carryOut = sumWide[SUM_W-1];
  end

  always_comb begin
    statusD = statusQ;
    if (strobe.writeCarry) begin
      statusD[CARRY_BIT] = carryOut;
      statusD[COPY_BIT]  = carryOut;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      resultQ <= '0;
    end else begin
      statusQ <= statusD;
      if (strobe.load) resultQ <= sumWide[DATA_W-1:0];
    end
  end

  assign result     = resultQ;
  assign statusWord = statusQ;

  // R5
  carry_pair_chk: assert property (@(posedge clk) disable iff (rst)
    statusQ[CARRY_BIT] == statusQ[COPY_BIT]);
  // R6
  keep_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.writeCarry |=> $stable(statusQ));
  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(resultQ));
  // R9
  other_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(statusQ) == 2 * 32'(statusQ[CARRY_BIT]));

endmodule

// File: rtl/addsubc_unit.sv
module addsubc_unit
  import addsubc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        opSub,
  input  logic        useCarry,
  input  logic        keep,
  output logic [31:0] result,
  output logic        resValid,
  output logic [31:0] statusWord
);

  ctrlStrobe_t strobe;

  addsubc_ctrl ctrl_i (
    .clk(clk), .rst(rst), .opValid(opValid), .opSub(opSub),
    .useCarry(useCarry), .keep(keep), .strobe(strobe), .resValid(resValid)
  );

  addsubc_dp #(.DATA_W(32), .STATUS_W(32), .CARRY_BIT(2), .COPY_BIT(31)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .opA(opA), .opB(opB),
    .result(result), .statusWord(statusWord)
  );

endmodule

// File: tb/addsubc_unit_tb_top.sv
module addsubc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        opValid, opSub, useCarry, keep;
  logic [31:0] opA, opB;
  logic [31:0] result, statusWord;
  logic        resValid;

  int checks = 0;
  int fails  = 0;
  logic modelCarry = 1'b0;
  logic [31:0] lastResult = '0;
  bit done = 0;

  always #2 clk = ~clk;

  addsubc_unit dut_i (
    .clk(clk), .rst(rst), .opValid(opValid), .opA(opA), .opB(opB),
    .opSub(opSub), .useCarry(useCarry), .keep(keep),
    .result(result), .resValid(resValid), .statusWord(statusWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] statusOf(input logic c);
    return c ? 32'h8000_0004 : 32'h0;
  endfunction

  // issue one op at a negedge, sample at the following negedge
  task automatic doOp(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic sub, input logic uc, input logic kp);
    logic cin;
    logic [32:0] wide;
    cin  = uc ? modelCarry : sub;
    wide = {1'b0, b} + {1'b0, (sub ? ~a : a)} + {32'b0, cin};
    opA = a; opB = b; opSub = sub; useCarry = uc; keep = kp; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    if (!kp) modelCarry = wide[32];
    lastResult = wide[31:0];
    check({req, " result"}, result, wide[31:0]);
    check("R7 valid", {31'b0, resValid}, 32'd1);
    check({req, " status"}, statusWord, statusOf(modelCarry));
  endtask

  task automatic testReset;
    rst = 1'b1; opValid = 1'b0; opA = '0; opB = '0; opSub = 0; useCarry = 0; keep = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 status", statusWord, 32'h0);
    check("R1 result", result, 32'h0);
    check("R1 valid", {31'b0, resValid}, 32'd0);
    modelCarry = 1'b0;
  endtask

  task automatic testAdd;
    doOp("R2 add", 32'd100, 32'd23, 0, 0, 0);
    doOp("R5 R2 add wrap", 32'hFFFF_FFFF, 32'd1, 0, 0, 0);
    doOp("R5 R2 add no carry", 32'h1234_5678, 32'h0000_1111, 0, 0, 0);
  endtask

  task automatic testSub;
    doOp("R3 R5 sub equal", 32'd5, 32'd5, 1, 0, 0);
    doOp("R3 R5 sub borrow", 32'd5, 32'd3, 1, 0, 0);
    doOp("R3 sub", 32'd7, 32'd1000, 1, 0, 0);
  endtask

  task automatic testUseCarry;
    doOp("R5 set carry", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    doOp("R4 add cin", 32'd0, 32'd0, 0, 1, 0);
    doOp("R4 sub cin0", 32'd2, 32'd10, 1, 1, 0);
  endtask

  task automatic testKeep;
    doOp("R5 clear", 32'd1, 32'd1, 0, 0, 0);
    doOp("R6 keep add", 32'hFFFF_FFFF, 32'd2, 0, 0, 1);
    doOp("R5 set", 32'd9, 32'd9, 1, 0, 0);
    doOp("R6 keep sub", 32'd9, 32'd1, 1, 0, 1);
    doOp("R6 R4 keep uc", 32'd4, 32'd4, 0, 1, 1);
  endtask

  task automatic testBackToBack;
    logic [32:0] w1, w2;
    // first: carry-out 1, second uses it in the very next cycle
    w1 = {1'b0, 32'h8000_0000} + {1'b0, 32'h8000_0000};
    w2 = {1'b0, 32'd10} + {1'b0, 32'd20} + {32'b0, w1[32]};
    opA = 32'h8000_0000; opB = 32'h8000_0000; opSub = 0; useCarry = 0; keep = 0; opValid = 1;
    @(negedge clk);
    check("R8 first result", result, w1[31:0]);
    check("R8 first status", statusWord, statusOf(w1[32]));
    opA = 32'd10; opB = 32'd20; useCarry = 1;
    @(negedge clk);
    opValid = 0;
    check("R8 chained result", result, w2[31:0]);
    check("R8 chained status", statusWord, statusOf(w2[32]));
    modelCarry = w2[32];
    lastResult = w2[31:0];
  endtask

  task automatic testIdle;
    opA = 32'hDEAD_BEEF; opB = 32'h1; opSub = 0; useCarry = 0; keep = 0;
    @(negedge clk);
    check("R7 idle valid", {31'b0, resValid}, 32'd0);
    check("R7 idle result", result, lastResult);
    check("R9 idle status", statusWord, statusOf(modelCarry));
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testAdd();
    testSub();
    testUseCarry();
    testKeep();
    testBackToBack();
    testIdle();
    testReset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule